// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps a 32-bit count of elapsed seconds and raises an alarm interrupt when the count reaches a programmed value. Software reaches it through a simple 16-bit register bus that uses byte addresses on a word-spaced map. A reference-clock divider turns the reference clock into one tick per second. Software programs the divider with the reference frequency in hertz. Each tick advances the count.

Software sets the time by writing a 32-bit load value and then raising a load request bit. To read the time, it raises a snapshot request bit, and the live count is copied into two read-only snapshot halves. Hardware drops each request bit once the transfer has been made, so software only needs to poll that bit. The alarm has a sticky pending flag. It can be masked, forced or cleared from the control register. A low soft-reset bit holds the divider, the count and the pending flag at zero, and it leaves every programmed register untouched.

Top module: `sec_alarm_timer`

## Requirements
- R1: The frequency (0x04 low, 0x08 high), load (0x0C/0x10) and match (0x14/0x18) halves read back as written. The status (0x1C) and snapshot (0x20/0x24) registers ignore writes. Any unmapped address reads 0.
- R2: While counting is enabled, the count advances once every F reference cycles, where F is the 32-bit frequency word. F = 0 or 1 advances it on every cycle. The first advance comes F edges after the enable write.
- R3: While control bit 1 (enable) is 0, the count and the divider do not advance.
- R4: Writing control bit 3 (load) copies the 32-bit load value into the count at the next clock edge. From that edge on, bit 3 reads 0.
- R5: Writing control bit 4 (snapshot) copies the count into the snapshot halves at the next clock edge. From that edge on, bit 4 reads 0.
- R6: Control bit 2 (wrap) selects what happens when a tick arrives at count 0xFFFFFFFF. With the bit at 0 the count stays at 0xFFFFFFFF. With the bit at 1 the count goes to 0.
- R7: A tick that leaves the count equal to the match value sets a sticky pending flag. Status bit 0 shows the pending flag OR'd with the force bit.
- R8: Control bit 5 (mask) at 1 holds `irq_o` low, and status bit 1 is 0. Status bit 0 still shows the pending flag.
- R9: Writing control bit 7 (clear) removes the pending flag at the following edge. Bit 7 always reads 0.
- R10: Control bit 6 (force) drives `irq_o` high while the mask bit is 0, whether or not an alarm is pending.
- R11: While control bit 0 is 0, the divider, the count and the pending flag are held at zero. The frequency, load and match registers keep their contents.
- R12: After `rst`, every register reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Alarm interrupt, active high |

## Verification
The hardest cases to reach from the ports are the ones at the ends of the 32-bit range: saturation at all-ones and the wrap to zero. The stimulus gets there by loading 0xFFFFFFFE and setting the divider to 1, so that every enabled cycle is a tick and the edge where the count crosses the boundary is known exactly. With the match register still at its reset value of 0, the same wrap also checks that the pending flag is set when the count arrives at the match value by wrapping. Divider timing is checked by counting edges between the enable write and the disable write, and then reading the result through a snapshot.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned CNT_W  = 2 * BUS_W;
    localparam int unsigned ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 6'h00,
        A_FRQ_L = 6'h04,
        A_FRQ_H = 6'h08,
        A_LD_L  = 6'h0C,
        A_LD_H  = 6'h10,
        A_MT_L  = 6'h14,
        A_MT_H  = 6'h18,
        A_STAT  = 6'h1C,
        A_SN_L  = 6'h20,
        A_SN_H  = 6'h24
    } reg_addr_e;

    // first field is bit 7, last field is bit 0
    typedef struct packed {
        logic clr;
        logic force_irq;
        logic mask;
        logic snap;
        logic load;
        logic wrap;
        logic en;
        logic run_n;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] freq;
        logic [CNT_W-1:0] ld;
        logic [CNT_W-1:0] match;
    } cfg_t;

    function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                    input logic wrap);
        if (&cur) return wrap ? '0 : cur;
        return cur + 1'b1;
    endfunction
endpackage

// File: rtl/sat_prescaler.sv
module sat_prescaler
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] freq,
    output logic             tick
);
    logic [CNT_W-1:0] div_q;
    logic             last;

    assign last = ({1'b0, div_q} + 1'b1) >= {1'b0, freq};
    assign tick = run & last;

    always_ff @(posedge clk) begin
        if (rst || !run)  div_q <= '0;
        else if (last)    div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/sat_core.sv
module sat_core
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  cfg_t             cfg,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] snap_q,
    output logic             pend_q,
    output logic             alarm_set
);
    logic [CNT_W-1:0] nxt;

    assign nxt       = next_count(cnt_q, ctrl.wrap);
    assign alarm_set = ctrl.run_n && !ctrl.load && tick && (nxt == cfg.match);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            snap_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (!ctrl.run_n)    cnt_q <= '0;
            else if (ctrl.load) cnt_q <= cfg.ld;
            else if (tick)      cnt_q <= nxt;

            if (ctrl.snap) snap_q <= cnt_q;

            if (!ctrl.run_n)    pend_q <= 1'b0;
            else if (alarm_set) pend_q <= 1'b1;
            else if (ctrl.clr)  pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sat_regs.sv
module sat_regs
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] snap,
    input  logic             pend,
    input  logic             irq,
    output ctrl_t            ctrl_q,
    output cfg_t             cfg_q,
    output logic [BUS_W-1:0] rdata
);
    localparam int unsigned CW = $bits(ctrl_t);

    ctrl_t ctrl_rd;
    wire   unused_hi = ^wdata[BUS_W-1:CW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            ctrl_q.load <= 1'b0;
            ctrl_q.snap <= 1'b0;
            ctrl_q.clr  <= 1'b0;
            if (wr_en) begin
                case (addr)
                    A_CTRL:  ctrl_q <= ctrl_t'(wdata[CW-1:0]);
                    A_FRQ_L: cfg_q.freq[BUS_W-1:0]      <= wdata;
                    A_FRQ_H: cfg_q.freq[CNT_W-1:BUS_W]  <= wdata;
                    A_LD_L:  cfg_q.ld[BUS_W-1:0]        <= wdata;
                    A_LD_H:  cfg_q.ld[CNT_W-1:BUS_W]    <= wdata;
                    A_MT_L:  cfg_q.match[BUS_W-1:0]     <= wdata;
                    A_MT_H:  cfg_q.match[CNT_W-1:BUS_W] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ctrl_rd     = ctrl_q;
        ctrl_rd.clr = 1'b0;
        case (addr)
            A_CTRL:  rdata = BUS_W'(ctrl_rd);
            A_FRQ_L: rdata = cfg_q.freq[BUS_W-1:0];
            A_FRQ_H: rdata = cfg_q.freq[CNT_W-1:BUS_W];
            A_LD_L:  rdata = cfg_q.ld[BUS_W-1:0];
            A_LD_H:  rdata = cfg_q.ld[CNT_W-1:BUS_W];
            A_MT_L:  rdata = cfg_q.match[BUS_W-1:0];
            A_MT_H:  rdata = cfg_q.match[CNT_W-1:BUS_W];
            A_STAT:  rdata = BUS_W'({irq, pend | ctrl_q.force_irq});
            A_SN_L:  rdata = snap[BUS_W-1:0];
            A_SN_H:  rdata = snap[CNT_W-1:BUS_W];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o
);
    ctrl_t            ctrl_q;
    cfg_t             cfg_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic             pend_q;
    logic             alarm_set;

    assign irq_o = (pend_q | ctrl_q.force_irq) & ~ctrl_q.mask;

    sat_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .snap   (snap_q),
        .pend   (pend_q),
        .irq    (irq_o),
        .ctrl_q (ctrl_q),
        .cfg_q  (cfg_q),
        .rdata  (bus_rdata)
    );

    sat_prescaler u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run_n & ctrl_q.en),
        .freq (cfg_q.freq),
        .tick (tick)
    );

    sat_core u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .cfg       (cfg_q),
        .tick      (tick),
        .cnt_q     (cnt_q),
        .snap_q    (snap_q),
        .pend_q    (pend_q),
        .alarm_set (alarm_set)
    );
endmodule

// File: rtl/sec_alarm_timer_chk.sv
module sec_alarm_timer_chk
    import sat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  ld_val,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  snap,
    input logic              pend,
    input logic              tick,
    input logic              alarm_set,
    input logic              irq_o
);
    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.run_n && !ctrl.load |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 32'd1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.run_n && !ctrl.en && !ctrl.load |=> cnt == $past(cnt));

    // R4
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.run_n && ctrl.load |=> cnt == $past(ld_val));

    // R4
    load_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.load && !(bus_wr && bus_addr == A_CTRL) |=> !ctrl.load);

    // R5
    snap_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.snap |=> snap == $past(cnt));

    // R6
    sat_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.run_n && !ctrl.load && !ctrl.wrap && (&cnt) |=> &cnt);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick && ctrl.run_n && !ctrl.load && ctrl.wrap && (&cnt) |=> cnt == '0);

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_set |=> pend);

    // R8
    mask_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.mask |-> !irq_o);

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.clr && !alarm_set |=> !pend);

    // R10
    force_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.force_irq && !ctrl.mask |-> irq_o);

    // R11
    srst_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run_n |=> cnt == '0 && !pend);

    // R12
    hw_rst_chk: assert property (@(posedge clk)
        rst |=> ctrl == '0 && cnt == '0 && !irq_o);
endmodule

bind sec_alarm_timer sec_alarm_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ctrl      (ctrl_q),
    .ld_val    (cfg_q.ld),
    .cnt       (cnt_q),
    .snap      (snap_q),
    .pend      (pend_q),
    .tick      (tick),
    .alarm_set (alarm_set),
    .irq_o     (irq_o)
);

// File: tb/sec_alarm_timer_bench.sv
`timescale 1ns/1ps
module sec_alarm_timer_bench;
    import sat_pkg::*;

    typedef enum logic [1:0] {OP_W, OP_R, OP_I} op_e;
    typedef struct packed {
        op_e         op;
        logic [5:0]  addr;
        logic [15:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    // R12 reset state, R1 readback, R4/R5 handshakes, R2/R3 timing, R11 soft reset
    localparam vec_t VECS [NV] = '{
        '{OP_R, 6'h00, 16'h0000, 8'd12},  // R12
        '{OP_R, 6'h1C, 16'h0000, 8'd12},  // R12
        '{OP_R, 6'h20, 16'h0000, 8'd12},  // R12
        '{OP_W, 6'h04, 16'h0003, 8'd0},
        '{OP_W, 6'h08, 16'h0000, 8'd0},
        '{OP_R, 6'h04, 16'h0003, 8'd1},   // R1
        '{OP_W, 6'h0C, 16'h1234, 8'd0},
        '{OP_W, 6'h10, 16'hABCD, 8'd0},
        '{OP_W, 6'h00, 16'h0009, 8'd0},
        '{OP_R, 6'h00, 16'h0009, 8'd4},   // R4 request visible
        '{OP_R, 6'h00, 16'h0001, 8'd4},   // R4 self-cleared
        '{OP_W, 6'h00, 16'h0011, 8'd0},
        '{OP_R, 6'h00, 16'h0011, 8'd5},   // R5
        '{OP_R, 6'h00, 16'h0001, 8'd5},   // R5
        '{OP_R, 6'h20, 16'h1234, 8'd4},   // R4 loaded value
        '{OP_R, 6'h24, 16'hABCD, 8'd4},   // R4
        '{OP_W, 6'h00, 16'h0003, 8'd0},
        '{OP_I, 6'h00, 16'd9,    8'd0},
        '{OP_W, 6'h00, 16'h0001, 8'd0},
        '{OP_W, 6'h00, 16'h0011, 8'd0},
        '{OP_I, 6'h00, 16'd1,    8'd0},
        '{OP_R, 6'h20, 16'h1237, 8'd2},   // R2 three ticks in ten edges
        '{OP_R, 6'h24, 16'hABCD, 8'd2},   // R2
        '{OP_I, 6'h00, 16'd5,    8'd0},
        '{OP_W, 6'h00, 16'h0011, 8'd0},
        '{OP_I, 6'h00, 16'd1,    8'd0},
        '{OP_R, 6'h20, 16'h1237, 8'd3},   // R3 no advance while disabled
        '{OP_W, 6'h20, 16'hFFFF, 8'd0},
        '{OP_R, 6'h20, 16'h1237, 8'd1},   // R1 snapshot ignores writes
        '{OP_R, 6'h3E, 16'h0000, 8'd1},   // R1 unmapped
        '{OP_W, 6'h00, 16'h0000, 8'd0},
        '{OP_W, 6'h00, 16'h0011, 8'd0},
        '{OP_I, 6'h00, 16'd1,    8'd0},
        '{OP_R, 6'h20, 16'h0000, 8'd11},  // R11 count zeroed
        '{OP_R, 6'h0C, 16'h1234, 8'd11},  // R11 registers kept
        '{OP_R, 6'h04, 16'h0003, 8'd11}   // R11
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    sec_alarm_timer u_sec_alarm_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic irq_is(input logic exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        n_chk++;
        if (irq_o !== exp) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_W: wr(VECS[i].addr, VECS[i].data);
                OP_I: idle(int'(VECS[i].data));
                default: rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d", VECS[i].req));
            endcase
        end

        // R6 saturation, divider of 1 (R2)
        wr(6'h04, 16'h0001);
        wr(6'h0C, 16'hFFFE); wr(6'h10, 16'hFFFF);
        wr(6'h00, 16'h0009); idle(1);
        wr(6'h00, 16'h0003); idle(4); wr(6'h00, 16'h0001);
        wr(6'h00, 16'h0011); idle(1);
        rd(6'h20, 16'hFFFF, "R6");
        rd(6'h24, 16'hFFFF, "R6");
        rd(6'h1C, 16'h0000, "R7");
        // R6 wrap to zero, which equals the reset match value (R7)
        wr(6'h00, 16'h0009); idle(1);
        wr(6'h00, 16'h0007); idle(1); wr(6'h00, 16'h0005);
        wr(6'h00, 16'h0015); idle(1);
        rd(6'h20, 16'h0000, "R6");
        rd(6'h24, 16'h0000, "R6");
        rd(6'h1C, 16'h0003, "R7");
        wr(6'h00, 16'h0081);
        rd(6'h00, 16'h0001, "R9");
        rd(6'h1C, 16'h0000, "R9");

        // R7 alarm on reaching match 5 from 2
        wr(6'h14, 16'h0005); wr(6'h18, 16'h0000);
        wr(6'h0C, 16'h0002); wr(6'h10, 16'h0000);
        wr(6'h00, 16'h0009); idle(1);
        rd(6'h14, 16'h0005, "R1");
        wr(6'h00, 16'h0003);
        irq_is(1'b0, "R7");
        irq_is(1'b0, "R7");
        irq_is(1'b0, "R7");
        irq_is(1'b1, "R7");
        rd(6'h1C, 16'h0003, "R7");
        wr(6'h00, 16'h0001);
        irq_is(1'b1, "R7");
        // R8 mask
        wr(6'h00, 16'h0021);
        irq_is(1'b0, "R8");
        rd(6'h1C, 16'h0001, "R8");
        wr(6'h00, 16'h0001);
        irq_is(1'b1, "R8");
        // R9 clear
        wr(6'h00, 16'h0081);
        rd(6'h00, 16'h0001, "R9");
        irq_is(1'b0, "R9");
        rd(6'h1C, 16'h0000, "R9");
        // R10 force
        wr(6'h00, 16'h0041);
        irq_is(1'b1, "R10");
        rd(6'h1C, 16'h0003, "R10");
        wr(6'h00, 16'h0061);
        irq_is(1'b0, "R10");
        rd(6'h1C, 16'h0001, "R10");
        wr(6'h00, 16'h0001);
        irq_is(1'b0, "R10");

        // R11 soft reset drops a pending alarm
        wr(6'h0C, 16'h0004);
        wr(6'h00, 16'h0009); idle(1);
        wr(6'h00, 16'h0003); wr(6'h00, 16'h0001);
        rd(6'h1C, 16'h0003, "R11");
        wr(6'h00, 16'h0000); idle(1);
        rd(6'h1C, 16'h0000, "R11");
        irq_is(1'b0, "R11");

        // R12 hardware reset mid-operation
        wr(6'h00, 16'h0043);
        @(negedge clk) begin bus_wr = 1'b0; rst = 1'b1; end
        repeat (2) @(negedge clk);
        rst = 1'b0;
        irq_is(1'b0, "R12");
        rd(6'h00, 16'h0000, "R12");
        rd(6'h04, 16'h0000, "R12");
        rd(6'h14, 16'h0000, "R12");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule